// File: doc/BRIEF.md
# SMBus Configuration Register Slave

This block is an SMBus slave that holds a byte-wide configuration register file for a signal-routing datapath. The SCL and SDA lines arrive as plain inputs and are oversampled on the system clock. The slave drives SDA only by pulling it low, through an output-enable. A 4-bit strap input sets the low nibble of the 7-bit device address. The upper three bits are fixed at `101`, so the address byte on the wire is `{3'b101, strap, rw}`. For example, strap `0001` gives byte 0xA2 and strap `1000` gives byte 0xB0.

A host writes one register with the sequence START, address+W, register index, data, STOP. It reads one register by sending the register index in a write phase, then a repeated START, address+R, and one data byte that the host answers with NACK. The whole register file is presented in parallel to the routing logic. The file returns to its default contents on reset, while the enable input is low, or when bit 0 of register 0x00 is written as 1.

Top module: `smb_cfg_slave`

## Requirements
- R1: An address byte whose upper seven bits equal `{3'b101, strap_i}` with R/W=0 is acknowledged: SDA is pulled low during the ninth clock.
- R2: An address byte that does not match is not acknowledged. Every byte that follows before the next START is neither acknowledged nor written.
- R3: A write of data D to implemented register index A (0x01 to 0x47) updates byte A of `reg_o` (bits A*8+7:A*8) to D after the data byte is acknowledged.
- R4: A read with a repeated START returns the register selected in the preceding write phase, MSB first, one bit per SCL period, starting after the address acknowledge.
- R5: Defaults: 0x20 at 0x0F, 0x16, 0x1D, 0x24, 0x2C and 0x3A. 0x03 at 0x17, 0x18, 0x25, 0x26, 0x2D, 0x2E, 0x34, 0x35, 0x3B, 0x3C, 0x42 and 0x43. 0x02 at 0x47. 0x00 at every other index.
- R6: While `en_i` is low, every register holds its default value and SDA is released. This takes effect one clock after `en_i` goes low.
- R7: Writing a byte with bit 0 set to register 0x00 restores every register to its default. Register 0x00 always reads 0x00.
- R8: A write to an index above 0x47 is acknowledged and has no effect on `reg_o`. A read of such an index returns 0x00.
- R9: The SDA output-enable changes only while SCL is low.
- R10: Only one data byte is accepted per write. A second data byte is not acknowledged, and it leaves both its target register and the next register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used to oversample the bus |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Block enable; low holds the slave and the register file in reset |
| strap_i | input | 4 | Low nibble of the 7-bit device address |
| scl_i | input | 1 | SMBus clock line |
| sda_i | input | 1 | SMBus data line (resolved bus value) |
| sda_oe_o | output | 1 | High pulls SDA low (open drain) |
| reg_o | output | 576 | Register file; byte i sits at bits i*8+7:i*8 |

## Verification
If the bit counter or the protocol state is wrong, the acknowledge falls on the wrong clock or is missing. A host sees this at the ninth clock of the same byte. A wrong register pointer, or a write strobe that fires when it should not, shows on `reg_o` a few cycles after the data acknowledge. The bench compares the whole register image after each transaction, so it also catches a write that lands on a neighbouring index. A reset path that restores the wrong values shows on `reg_o` one clock after the enable drops or after the soft-reset write.

// File: rtl/smb_cfg_pkg.sv
package smb_cfg_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_INDEX,
    ST_INDEX_ACK,
    ST_WDATA,
    ST_WDATA_ACK,
    ST_TX,
    ST_SKIP
  } smb_state_e;

  // reset value of each register index
  function automatic logic [7:0] reg_default(int unsigned idx);
    case (idx)
      'h0F, 'h16, 'h1D, 'h24, 'h2C, 'h3A: return 8'h20;
      'h17, 'h18, 'h25, 'h26, 'h2D, 'h2E,
      'h34, 'h35, 'h3B, 'h3C, 'h42, 'h43: return 8'h03;
      'h47:                               return 8'h02;
      default:                            return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/smb_sync.sv
module smb_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o,
  output logic [WIDTH-1:0] q_prev_o
);
  logic [STAGES-1:0][WIDTH-1:0] stage_q;
  logic [WIDTH-1:0]             prev_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [WIDTH-1:0] src;
    if (s == 0) begin : g_first
      assign src = d_i;
    end else begin : g_next
      assign src = stage_q[s-1];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    stage_q[s] <= '1;
      else if (clr_i) stage_q[s] <= '1;
      else            stage_q[s] <= src;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    prev_q <= '1;
    else if (clr_i) prev_q <= '1;
    else            prev_q <= stage_q[STAGES-1];
  end

  assign q_o      = stage_q[STAGES-1];
  assign q_prev_o = prev_q;
endmodule

// File: rtl/smb_slave_fsm.sv
module smb_slave_fsm
  import smb_cfg_pkg::*;
#(
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned STRAP_W = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clr_i,
  input  logic               scl_i,
  input  logic               scl_prev_i,
  input  logic               sda_i,
  input  logic               sda_prev_i,
  input  logic [STRAP_W-1:0] strap_i,
  input  logic [7:0]         rd_data_i,
  output logic               sda_oe_o,
  output logic               wr_en_o,
  output logic [ADDR_W-1:0]  wr_addr_o,
  output logic [7:0]         wr_data_o,
  output logic [ADDR_W-1:0]  rd_addr_o
);
  localparam logic [6:0] BASE_ADDR = 7'b1010000;

  smb_state_e        state_q;
  logic [7:0]        shift_q;
  logic [3:0]        bit_cnt_q;
  logic [2:0]        tx_idx_q;
  logic [7:0]        tx_q;
  logic [ADDR_W-1:0] ptr_q;
  logic              rw_q;

  logic       scl_rise, scl_fall, start_det, stop_det, byte_done;
  logic [6:0] dev_addr;

  assign scl_rise  = scl_i & ~scl_prev_i;
  assign scl_fall  = ~scl_i & scl_prev_i;
  assign start_det = scl_i & scl_prev_i & sda_prev_i & ~sda_i;
  assign stop_det  = scl_i & scl_prev_i & ~sda_prev_i & sda_i;
  assign byte_done = scl_fall & (bit_cnt_q == 4'd8);
  assign dev_addr  = {BASE_ADDR[6:STRAP_W], strap_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      shift_q   <= '0;
      bit_cnt_q <= '0;
      tx_idx_q  <= '0;
      tx_q      <= '0;
      ptr_q     <= '0;
      rw_q      <= 1'b0;
      sda_oe_o  <= 1'b0;
      wr_en_o   <= 1'b0;
      wr_addr_o <= '0;
      wr_data_o <= '0;
    end else if (clr_i) begin
      state_q   <= ST_IDLE;
      bit_cnt_q <= '0;
      ptr_q     <= '0;
      sda_oe_o  <= 1'b0;
      wr_en_o   <= 1'b0;
    end else begin
      wr_en_o <= 1'b0;
      if (start_det) begin
        state_q   <= ST_ADDR;
        bit_cnt_q <= '0;
        sda_oe_o  <= 1'b0;
      end else if (stop_det) begin
        state_q  <= ST_IDLE;
        sda_oe_o <= 1'b0;
      end else begin
        unique case (state_q)
          ST_ADDR, ST_INDEX, ST_WDATA: begin
            if (scl_rise && bit_cnt_q != 4'd8) begin
              shift_q   <= {shift_q[6:0], sda_i};
              bit_cnt_q <= bit_cnt_q + 4'd1;
            end
            if (byte_done) begin
              bit_cnt_q <= '0;
              if (state_q == ST_ADDR) begin
                if (shift_q[7:1] == dev_addr) begin
                  rw_q     <= shift_q[0];
                  sda_oe_o <= 1'b1;
                  state_q  <= ST_ADDR_ACK;
                end else begin
                  state_q  <= ST_SKIP;
                end
              end else if (state_q == ST_INDEX) begin
                ptr_q    <= shift_q[ADDR_W-1:0];
                sda_oe_o <= 1'b1;
                state_q  <= ST_INDEX_ACK;
              end else begin
                wr_en_o   <= 1'b1;
                wr_addr_o <= ptr_q;
                wr_data_o <= shift_q;
                sda_oe_o  <= 1'b1;
                state_q   <= ST_WDATA_ACK;
              end
            end
          end
          ST_ADDR_ACK: if (scl_fall) begin
            if (rw_q) begin
              tx_q     <= rd_data_i;
              tx_idx_q <= 3'd7;
              sda_oe_o <= ~rd_data_i[7];
              state_q  <= ST_TX;
            end else begin
              sda_oe_o <= 1'b0;
              state_q  <= ST_INDEX;
            end
          end
          ST_INDEX_ACK: if (scl_fall) begin
            sda_oe_o <= 1'b0;
            state_q  <= ST_WDATA;
          end
          ST_WDATA_ACK: if (scl_fall) begin
            sda_oe_o <= 1'b0;
            state_q  <= ST_SKIP;  // one data byte per write
          end
          ST_TX: if (scl_fall) begin
            if (tx_idx_q == 3'd0) begin
              sda_oe_o <= 1'b0;
              state_q  <= ST_SKIP;
            end else begin
              tx_idx_q <= tx_idx_q - 3'd1;
              sda_oe_o <= ~tx_q[tx_idx_q - 3'd1];
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign rd_addr_o = ptr_q;
endmodule

// File: rtl/smb_regfile.sv
module smb_regfile
  import smb_cfg_pkg::*;
#(
  parameter int unsigned NUM_REGS = 72,
  parameter int unsigned ADDR_W   = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  clr_i,
  input  logic                  wr_en_i,
  input  logic [ADDR_W-1:0]     wr_addr_i,
  input  logic [7:0]            wr_data_i,
  input  logic [ADDR_W-1:0]     rd_addr_i,
  output logic [7:0]            rd_data_o,
  output logic [NUM_REGS*8-1:0] regs_o
);
  localparam int unsigned       IDX_W    = $clog2(NUM_REGS);
  localparam logic [ADDR_W-1:0] LAST_IDX = ADDR_W'(NUM_REGS - 1);

  logic [NUM_REGS-1:0][7:0] regs_q;
  logic soft_rst, wr_hit;

  assign soft_rst = wr_en_i && (wr_addr_i == '0) && wr_data_i[0];
  // index 0 holds only the self-clearing reset bit: never stored
  assign wr_hit   = wr_en_i && (wr_addr_i != '0) && (wr_addr_i <= LAST_IDX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_REGS; i++) regs_q[i] <= reg_default(i);
    end else if (clr_i || soft_rst) begin
      for (int i = 0; i < NUM_REGS; i++) regs_q[i] <= reg_default(i);
    end else if (wr_hit) begin
      regs_q[wr_addr_i[IDX_W-1:0]] <= wr_data_i;
    end
  end

  assign rd_data_o = (rd_addr_i <= LAST_IDX) ? regs_q[rd_addr_i[IDX_W-1:0]] : 8'h00;
  assign regs_o    = regs_q;
endmodule

// File: rtl/smb_cfg_slave.sv
module smb_cfg_slave #(
  parameter int unsigned NUM_REGS    = 72,
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned STRAP_W     = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  en_i,
  input  logic [STRAP_W-1:0]    strap_i,
  input  logic                  scl_i,
  input  logic                  sda_i,
  output logic                  sda_oe_o,
  output logic [NUM_REGS*8-1:0] reg_o
);
  logic              clr;
  logic [1:0]        bus_q, bus_prev_q;
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr, rd_addr;
  logic [7:0]        wr_data, rd_data;

  assign clr = ~en_i;

  smb_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (clr),
    .d_i      ({scl_i, sda_i}),
    .q_o      (bus_q),
    .q_prev_o (bus_prev_q)
  );

  smb_slave_fsm #(.ADDR_W(ADDR_W), .STRAP_W(STRAP_W)) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (clr),
    .scl_i      (bus_q[1]),
    .scl_prev_i (bus_prev_q[1]),
    .sda_i      (bus_q[0]),
    .sda_prev_i (bus_prev_q[0]),
    .strap_i    (strap_i),
    .rd_data_i  (rd_data),
    .sda_oe_o   (sda_oe_o),
    .wr_en_o    (wr_en),
    .wr_addr_o  (wr_addr),
    .wr_data_o  (wr_data),
    .rd_addr_o  (rd_addr)
  );

  smb_regfile #(.NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (clr),
    .wr_en_i   (wr_en),
    .wr_addr_i (wr_addr),
    .wr_data_i (wr_data),
    .rd_addr_i (rd_addr),
    .rd_data_o (rd_data),
    .regs_o    (reg_o)
  );
endmodule

// File: rtl/smb_cfg_slave_chk.sv
module smb_cfg_slave_chk
  import smb_cfg_pkg::*;
#(
  parameter int unsigned NUM_REGS = 72,
  parameter int unsigned STRAP_W  = 4
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  en_i,
  input logic [STRAP_W-1:0]    strap_i,
  input logic                  scl_i,
  input logic                  sda_i,
  input logic                  sda_oe_o,
  input logic [NUM_REGS*8-1:0] reg_o
);
  function automatic logic [NUM_REGS*8-1:0] default_image();
    logic [NUM_REGS*8-1:0] img;
    for (int i = 0; i < NUM_REGS; i++) img[i*8 +: 8] = reg_default(i);
    return img;
  endfunction

  localparam logic [NUM_REGS*8-1:0] DEF_IMG = default_image();

  assert_disable_defaults_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (reg_o == DEF_IMG));

  assert_disable_release_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !sda_oe_o);

  assert_index0_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_o[7:0] == 8'h00);

  assert_oe_moves_scl_low_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_oe_o) |-> !scl_i);
endmodule

bind smb_cfg_slave smb_cfg_slave_chk #(.NUM_REGS(NUM_REGS), .STRAP_W(STRAP_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .en_i     (en_i),
  .strap_i  (strap_i),
  .scl_i    (scl_i),
  .sda_i    (sda_i),
  .sda_oe_o (sda_oe_o),
  .reg_o    (reg_o)
);

// File: tb/smb_cfg_slave_test.sv
`timescale 1ns/1ps
module smb_cfg_slave_test;
  localparam int NREG = 72;
  localparam int Q    = 6;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            en = 1'b1;
  logic [3:0]      strap = 4'b0000;
  logic            scl_m = 1'b1;
  logic            sda_m = 1'b1;
  logic            sda_oe;
  logic [NREG*8-1:0] reg_o;
  wire             sda_line = sda_m & ~sda_oe;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;
  logic [7:0] model [NREG];

  always #10 clk = ~clk;

  smb_cfg_slave uut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .strap_i(strap),
    .scl_i(scl_m), .sda_i(sda_line), .sda_oe_o(sda_oe), .reg_o(reg_o)
  );

  function automatic logic [7:0] dflt(int a);
    if (a == 'h0F || a == 'h16 || a == 'h1D || a == 'h24 || a == 'h2C || a == 'h3A) return 8'h20;
    if (a == 'h17 || a == 'h18 || a == 'h25 || a == 'h26 || a == 'h2D || a == 'h2E ||
        a == 'h34 || a == 'h35 || a == 'h3B || a == 'h3C || a == 'h42 || a == 'h43) return 8'h03;
    if (a == 'h47) return 8'h02;
    return 8'h00;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < NREG; i++) model[i] = dflt(i);
  endtask

  task automatic model_write(input logic [7:0] a, input logic [7:0] d);
    if (a == 8'h00) begin
      if (d[0]) model_reset();
    end else if (a < NREG) begin
      model[a] = d;
    end
  endtask

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic check_image(input string req);
    for (int i = 0; i < NREG; i++) check(req, 32'(reg_o[i*8 +: 8]), 32'(model[i]));
  endtask

  task automatic w();
    repeat (Q) @(negedge clk);
  endtask

  task automatic b_start();
    sda_m = 1'b1; scl_m = 1'b1; w(); sda_m = 1'b0; w(); scl_m = 1'b0; w();
  endtask

  task automatic b_rstart();
    sda_m = 1'b1; w(); scl_m = 1'b1; w(); sda_m = 1'b0; w(); scl_m = 1'b0; w();
  endtask

  task automatic b_stop();
    sda_m = 1'b0; w(); scl_m = 1'b1; w(); sda_m = 1'b1; w();
  endtask

  task automatic b_wbyte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; w(); scl_m = 1'b1; w(); w(); scl_m = 1'b0; @(negedge clk);
    end
    sda_m = 1'b1; w(); scl_m = 1'b1; w(); ack = ~sda_line; w(); scl_m = 1'b0; @(negedge clk);
  endtask

  task automatic b_rbyte(output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      w(); scl_m = 1'b1; w(); b[i] = sda_line; w(); scl_m = 1'b0; @(negedge clk);
    end
    sda_m = 1'b1; w(); scl_m = 1'b1; w(); w(); scl_m = 1'b0; @(negedge clk);  // NACK
  endtask

  task automatic reg_write(input logic [6:0] dev, input logic [7:0] a, input logic [7:0] d,
                           output logic ok);
    logic a0, a1, a2;
    b_start();
    b_wbyte({dev, 1'b0}, a0);
    b_wbyte(a, a1);
    b_wbyte(d, a2);
    b_stop();
    ok = a0 & a1 & a2;
  endtask

  task automatic reg_read(input logic [6:0] dev, input logic [7:0] a, output logic [7:0] d,
                          output logic ok);
    logic a0, a1, a2;
    b_start();
    b_wbyte({dev, 1'b0}, a0);
    b_wbyte(a, a1);
    b_rstart();
    b_wbyte({dev, 1'b1}, a2);
    b_rbyte(d);
    b_stop();
    ok = a0 & a1 & a2;
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : stim
    logic ok, ack;
    logic [7:0] rd;
    logic [6:0] dev;
    int unsigned seed_init;
    seed_init = $urandom(32'd1357);
    model_reset();
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R5 reset image, R9 idle bus released
    check_image("R5 reset image");
    check("R9 idle release", 32'(sda_oe), 0);

    dev = 7'h50;
    reg_read(dev, 8'h0F, rd, ok);
    check("R4 read ack", 32'(ok), 1);
    check("R5 read default 0x0F", 32'(rd), 32'h20);
    reg_read(dev, 8'h47, rd, ok);
    check("R5 read default 0x47", 32'(rd), 32'h02);

    // R1 strap 0001 -> byte 0xA2
    strap = 4'b0001; dev = 7'h51; @(negedge clk);
    reg_write(dev, 8'h10, 8'h5A, ok); model_write(8'h10, 8'h5A);
    check("R1 strap 0001 ack", 32'(ok), 1);
    check("R3 reg_o 0x10", 32'(reg_o[8'h10*8 +: 8]), 32'h5A);
    reg_read(dev, 8'h10, rd, ok);
    check("R4 readback 0x10", 32'(rd), 32'h5A);

    // R2 mismatching address: no ack, following bytes ignored
    b_start();
    b_wbyte(8'hA0, ack); check("R2 no ack", 32'(ack), 0);
    b_wbyte(8'h10, ack); check("R2 index ignored", 32'(ack), 0);
    b_wbyte(8'hC3, ack); check("R2 data ignored", 32'(ack), 0);
    b_stop();
    check_image("R2 image unchanged");

    // R1 strap 1000 -> byte 0xB0
    strap = 4'b1000; dev = 7'h58; @(negedge clk);
    reg_write(dev, 8'h20, 8'hE7, ok); model_write(8'h20, 8'hE7);
    check("R1 strap 1000 ack", 32'(ok), 1);
    check_image("R3 write 0x20");

    // R10 second data byte refused
    b_start();
    b_wbyte({dev, 1'b0}, ack);
    b_wbyte(8'h11, ack);
    b_wbyte(8'h33, ack); check("R10 first data ack", 32'(ack), 1);
    b_wbyte(8'h44, ack); check("R10 second data nack", 32'(ack), 0);
    b_stop();
    model_write(8'h11, 8'h33);
    check_image("R10 image");

    // R8 unimplemented index
    reg_write(dev, 8'h60, 8'h99, ok);
    check("R8 write ack", 32'(ok), 1);
    check_image("R8 image unchanged");
    reg_read(dev, 8'h60, rd, ok);
    check("R8 read zero", 32'(rd), 0);
    reg_read(dev, 8'hFF, rd, ok);
    check("R8 read 0xFF zero", 32'(rd), 0);

    // R7 soft reset
    reg_write(dev, 8'h00, 8'h01, ok); model_write(8'h00, 8'h01);
    check("R7 ack", 32'(ok), 1);
    check_image("R7 defaults");
    reg_read(dev, 8'h00, rd, ok);
    check("R7 index0 reads 0", 32'(rd), 0);
    reg_write(dev, 8'h00, 8'hFE, ok);
    check_image("R7 bit0 clear no reset");

    // R6 enable drop
    reg_write(dev, 8'h30, 8'h77, ok); model_write(8'h30, 8'h77);
    check_image("R6 before disable");
    en = 1'b0; repeat (3) @(negedge clk);
    model_reset();
    check_image("R6 disabled defaults");
    check("R6 sda released", 32'(sda_oe), 0);
    en = 1'b1; repeat (3) @(negedge clk);
    reg_write(dev, 8'h30, 8'h12, ok); model_write(8'h30, 8'h12);
    check("R6 working after enable", 32'(reg_o[8'h30*8 +: 8]), 32'h12);

    // random traffic (R3, R4, R8)
    for (int k = 0; k < 30; k++) begin
      logic [7:0] a, d;
      a = 8'($urandom_range(1, 'h50));
      d = 8'($urandom);
      reg_write(dev, a, d, ok); model_write(a, d);
      check("R3 random write ack", 32'(ok), 1);
      reg_read(dev, a, rd, ok);
      check("R4 random readback", 32'(rd), 32'((a < NREG) ? model[a] : 8'h00));
      if (k % 10 == 9) check_image("R3 random image");
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule